// File: doc/BRIEF.md
# Refresh Request Handshake Generator

This block sits in the fabric and takes over DRAM refresh scheduling from a memory controller. After the controller reports that it is ready, an internal interval timer ticks once per programmed interval. Each tick adds one owed refresh to every enabled rank. Each rank pays its debt through a four-phase request/acknowledge handshake with the controller. The request is raised, held until the acknowledge is seen high, dropped, and the rank then waits for the acknowledge to fall before it may raise again.

The ready and acknowledge inputs come from the controller's clock domain. Both pass through a two-flop synchronizer before any logic uses them. A mode input makes all enabled ranks start their handshakes in the same cycle, for stacked multi-rank setups. Each rank may owe at most six refreshes. A tick that would push a rank past that limit sets a sticky error flag. When ready drops, the timer pauses and no new request starts. The owed counts are kept, and the handshakes resume when ready returns.

Top module: `refresh_req_gen`

## Requirements
- R1: After reset `req_o` is all zero and `err_o` is 0. No request bit rises while the synchronized ready is low.
- R2: Each rank bit follows a four-phase sequence. It rises only while its synchronized ack is low. It stays high until the synchronized ack is high, then falls. It does not rise again until the synchronized ack has been seen low.
- R3: With `ready_i` high, the timer ticks once every `interval_i` clock cycles (a value of 0 acts as 1). Each tick adds one owed refresh to every enabled rank, and each owed refresh produces exactly one request rise.
- R4: A rank whose bit in `rank_en_i` is 0 gains no owed refreshes and never raises its request.
- R5: A rank's owed count never exceeds 6. A tick that would raise it to 7 sets `err_o`. `err_o` stays set until reset.
- R6: Over any run, all enabled ranks see the same number of request rises.
- R7: With `all_rank_i` high, every request rise happens in the same cycle on all enabled ranks. The group starts only when every enabled rank is idle and owes a refresh.
- R8: While `ready_i` is low, the timer pauses and no new request rises. A request already raised stays high until its ack arrives. The owed counts are kept, and the handshakes resume once ready returns.
- R9: A request falls no more than three clock cycles after its `ack_i` bit goes high: two synchronizer stages and one state register, with no extra hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rank_en_i | input | NUM_RANKS | Per-rank enable mask |
| all_rank_i | input | 1 | Issue each request to all enabled ranks at once |
| interval_i | input | INTERVAL_W | Refresh interval in clock cycles |
| ready_i | input | 1 | Controller ready / calibration done, asynchronous |
| ack_i | input | NUM_RANKS | Per-rank acknowledge, asynchronous |
| req_o | output | NUM_RANKS | Per-rank refresh request |
| err_o | output | 1 | Sticky flag: owed-refresh limit exceeded |

## Verification
The bench builds the block with its defaults: four ranks, a 16-bit interval, a limit of six owed refreshes and two synchronizer stages. With four ranks, both mixed enable masks and full-group starts can be exercised. Intervals of 20 to 96 cycles make the seventh postponed tick, the overflow flag and a full pause-and-resume of ready reachable within a few hundred cycles. Acknowledge delays of up to eight cycles let the ranks finish their handshakes at different times.

// File: rtl/rrg_pkg.sv
package rrg_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_DROP = 2'd2
  } hs_state_e;
endpackage

// File: rtl/rrg_sync.sv
module rrg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rrg_timer.sv
module rrg_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] interval_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last   = (interval_i == '0) ? '0 : interval_i - W'(1);
  // >= so a shortened interval never lets the counter run away
  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rrg_rank.sv
module rrg_rank
  import rrg_pkg::*;
#(
  parameter int MAX_OWED = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic ready_i,
  input  logic ack_i,
  input  logic group_ok_i,
  output logic idle_o,
  output logic pend_o,
  output logic ovf_o,
  output logic req_o
);
  localparam int OWED_W = $clog2(MAX_OWED + 1);

  hs_state_e   state_q, state_d;
  logic [OWED_W-1:0] owed_q;
  logic inc, dec, start;

  assign inc    = tick_i && en_i;
  assign dec    = (state_q == HS_REQ) && ack_i;
  assign start  = (state_q == HS_IDLE) && en_i && ready_i && !ack_i
                  && (owed_q != '0) && group_ok_i;
  assign ovf_o  = inc && !dec && (owed_q == OWED_W'(MAX_OWED));
  assign idle_o = (state_q == HS_IDLE);
  assign pend_o = (owed_q != '0);
  assign req_o  = (state_q == HS_REQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (start)   state_d = HS_REQ;
      HS_REQ:  if (ack_i)   state_d = HS_DROP;
      HS_DROP: if (!ack_i)  state_d = HS_IDLE;
      default:              state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      owed_q  <= '0;
    end else begin
      state_q <= state_d;
      if (inc && !dec && !ovf_o) owed_q <= owed_q + OWED_W'(1);
      else if (dec && !inc)      owed_q <= owed_q - OWED_W'(1);
    end
  end

  a_r2_drop_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(ack_i));
  a_r2_rise_ack_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(ack_i));
  a_r1_rise_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(ready_i));
  a_r4_rise_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(en_i));
  a_r5_owed_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= OWED_W'(MAX_OWED));
endmodule

// File: rtl/refresh_req_gen.sv
module refresh_req_gen #(
  parameter int NUM_RANKS   = 4,
  parameter int INTERVAL_W  = 16,
  parameter int MAX_OWED    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_RANKS-1:0]  rank_en_i,
  input  logic                  all_rank_i,
  input  logic [INTERVAL_W-1:0] interval_i,
  input  logic                  ready_i,
  input  logic [NUM_RANKS-1:0]  ack_i,
  output logic [NUM_RANKS-1:0]  req_o,
  output logic                  err_o
);
  logic                 ready_s, tick;
  logic [NUM_RANKS-1:0] ack_s, idle, pend, ovf;
  logic                 group_ok, err_q;

  rrg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_rdy (
    .clk_i, .rst_ni, .d_i(ready_i), .q_o(ready_s));

  rrg_sync #(.W(NUM_RANKS), .STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i, .rst_ni, .d_i(ack_i), .q_o(ack_s));

  rrg_timer #(.W(INTERVAL_W)) u_timer (
    .clk_i, .rst_ni, .run_i(ready_s), .interval_i, .tick_o(tick));

  // group start: every enabled rank idle and owing
  assign group_ok = !all_rank_i ||
                    ((&(idle | ~rank_en_i)) && (&(pend | ~rank_en_i)));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rrg_rank #(.MAX_OWED(MAX_OWED)) u_rank (
      .clk_i, .rst_ni,
      .en_i      (rank_en_i[r]),
      .tick_i    (tick),
      .ready_i   (ready_s),
      .ack_i     (ack_s[r]),
      .group_ok_i(group_ok),
      .idle_o    (idle[r]),
      .pend_o    (pend[r]),
      .ovf_o     (ovf[r]),
      .req_o     (req_o[r]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= 1'b0;
    else if (|ovf) err_q <= 1'b1;
  end
  assign err_o = err_q;

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r7_group_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(all_rank_i) && |(req_o & ~$past(req_o)))
      |-> ((req_o & ~$past(req_o)) == $past(rank_en_i)));
endmodule

// File: tb/refresh_req_gen_tb.sv
`timescale 1ns/1ps
module refresh_req_gen_tb;
  localparam int NR = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR-1:0] rank_en_i = '1;
  logic          all_rank_i = 1'b0;
  logic [15:0]   interval_i = 16'd64;
  logic          ready_i = 1'b0;
  logic [NR-1:0] ack_i = '0;
  logic [NR-1:0] req_o;
  logic          err_o;

  refresh_req_gen u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  int rises [NR];
  int hi_cnt[NR];
  int wait_c[NR];
  int viol = 0, allv = 0, max_lat = 0;
  bit ack_auto = 1'b1;
  logic [NR-1:0] prev_req = '0;

  // monitor then ack model, all on the falling edge
  always @(negedge clk_i) begin
    logic [NR-1:0] rise, fall;
    cyc++;
    rise = req_o & ~prev_req;
    fall = ~req_o & prev_req;
    if (all_rank_i && rise != '0 && rise != rank_en_i) allv++;
    for (int r = 0; r < NR; r++) begin
      if (rise[r]) begin
        rises[r]++;
        hi_cnt[r] = 0;
        if (ack_i[r]) viol++;
      end
      if (fall[r]) begin
        if (!ack_i[r]) viol++;
        if (hi_cnt[r] > max_lat) max_lat = hi_cnt[r];
      end
      if (req_o[r] && ack_i[r]) hi_cnt[r]++;
    end
    prev_req = req_o;
    for (int r = 0; r < NR; r++) begin
      if (ack_auto && ack_i[r] != req_o[r]) begin
        if (wait_c[r] == 0) begin
          ack_i[r] = req_o[r];
          wait_c[r] = $urandom % 9;
        end else wait_c[r]--;
      end
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_rises(int cycles, int itv);
    return cycles / itv;
  endfunction

  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    @(posedge clk_i);
    for (int r = 0; r < NR; r++) rises[r] = 0;
    viol = 0; allv = 0; max_lat = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // counts and protocol after a window with ready high from reset
  task automatic check_window(input logic [NR-1:0] en, input int n, input int itv);
    int ref_r;
    ref_r = -1;
    for (int r = 0; r < NR; r++) begin
      if (en[r]) begin
        chk(absdiff(rises[r], exp_rises(n, itv)) <= 1, "R3 rises per interval",
            rises[r], exp_rises(n, itv));
        if (ref_r < 0) ref_r = rises[r];
        else chk(rises[r] == ref_r, "R6 equal count", rises[r], ref_r);
      end else begin
        chk(rises[r] == 0, "R4 disabled rank quiet", rises[r], 0);
      end
    end
    chk(viol == 0, "R2 handshake order", viol, 0);
    chk(max_lat <= 3, "R9 drop latency", max_lat, 3);
    chk(err_o == 1'b0, "R5 no error", err_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NR; r++) begin rises[r] = 0; hi_cnt[r] = 0; wait_c[r] = 0; end

    // R1: reset state and no requests while not ready
    do_reset();
    interval_i = 16'd8;
    run(2);
    chk(req_o == '0, "R1 reset req", req_o, 0);
    chk(err_o == 1'b0, "R1 reset err", err_o, 0);
    clear_stats();
    run(200);
    chk(rises[0] + rises[1] + rises[2] + rises[3] == 0, "R1 quiet until ready",
        rises[0] + rises[1] + rises[2] + rises[3], 0);

    // R3/R6/R2/R9: all ranks, fixed interval
    interval_i = 16'd64;
    ready_i = 1'b1;
    do_reset();
    clear_stats();
    run(64 * 20);
    check_window(4'hF, 64 * 20, 64);

    // R4: partial mask
    rank_en_i = 4'b0101;
    do_reset();
    clear_stats();
    run(64 * 10);
    check_window(4'b0101, 64 * 10, 64);

    // R7: group mode
    rank_en_i = 4'hF;
    all_rank_i = 1'b1;
    do_reset();
    clear_stats();
    run(64 * 10);
    chk(allv == 0, "R7 group rise", allv, 0);
    check_window(4'hF, 64 * 10, 64);
    all_rank_i = 1'b0;

    // random rounds
    for (int k = 0; k < 6; k++) begin
      int itv;
      itv = 32 + int'($urandom % 65);
      interval_i = 16'(itv);
      rank_en_i = 4'($urandom % 15 + 1);
      all_rank_i = 1'($urandom % 2);
      do_reset();
      clear_stats();
      run(itv * 12);
      chk(allv == 0, "R7 group rise random", allv, 0);
      check_window(rank_en_i, itv * 12, itv);
    end
    all_rank_i = 1'b0;
    rank_en_i = 4'hF;

    // R5: no acks, seventh owed tick sets error
    ack_auto = 1'b0;
    ack_i = '0;
    interval_i = 16'd20;
    do_reset();
    run(132);
    chk(err_o == 1'b0, "R5 six owed no error", err_o, 0);
    run(20);
    chk(err_o == 1'b1, "R5 seventh owed error", err_o, 1);
    ack_auto = 1'b1;
    run(400);
    chk(err_o == 1'b1, "R5 error sticky", err_o, 1);

    // R8: ready drop pauses timer, holds request and owed
    ack_auto = 1'b0;
    ack_i = '0;
    do_reset();
    run(50);
    ready_i = 1'b0;
    run(400);
    chk(err_o == 1'b0, "R8 timer paused", err_o, 0);
    chk(req_o == 4'hF, "R8 request held", req_o, 15);
    clear_stats();
    ack_auto = 1'b1;
    run(200);
    chk(rises[0] + rises[1] + rises[2] + rises[3] == 0, "R8 no new rise unready",
        rises[0] + rises[1] + rises[2] + rises[3], 0);
    chk(req_o == '0, "R8 held request completes", req_o, 0);
    ready_i = 1'b1;
    run(60);
    chk(rises[0] >= 1 && rises[0] == rises[3], "R8 resumes owed", rises[0], 1);
    chk(viol == 0, "R2 order over pause", viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule